// File: doc/BRIEF.md
# Issue-Driven Clock-Enable Controller

This block sits right after the issue stage of a wide out-of-order back end. It computes one clock enable per gated resource: each execution unit, each back-end pipeline-latch slot, each data-cache wordline decoder port and each result-bus driver. It uses only the instructions that issued in the current cycle. The register-read stage gives at least one cycle between issue and first use, and the block spends that cycle registering each enable. The enable is therefore stable for the whole cycle in which the resource works. Nothing is predicted, so a resource is never starved of clock when an issued instruction needs it. A resource idles for exactly the cycles it is unused, so the gating granularity is one cycle.

Each issue slot presents a valid bit with a target unit index, a unit class, a memory-access flag and a writes-result flag. The issue side is a stream with per-slot valid and no ready. The controller never applies back-pressure: every valid slot is accepted in the cycle it is presented, and a slot whose valid is low is ignored completely. Every enable drives a gated-clock cell. The cell holds the enable in a latch that is open while the clock is low, and ANDs the latch output with the clock.

Top module: `issue_clk_gate_ctrl`

## Requirements
- R1: The enable of unit u is high in the cycle after issue exactly when at least one valid slot targeted unit u. The unit index is bits [s*UNIT_W +: UNIT_W] of `iss_unit` for slot s.
- R2: The latch-slot enable bit s is high in the cycle after issue exactly when slot s was valid.
- R3: If k valid slots have the memory flag set, decoder-port enable bits 0 to k-1 are high in the cycle after issue and all higher bits are low. Ports are handed out from bit 0 upward. Inputs guarantee that k never exceeds NUM_PORTS.
- R4: A valid instruction of class c with the writes-result flag set, targeting unit u, raises driver-enable bit u exactly D(c) cycles after its issue cycle, for one cycle. D(c) is bits [4c +: 4] of CLS_DLY; the defaults are 1, 2, 3 and 4 for classes 0 to 3. The class is bits [s*CLS_W +: CLS_W] of `iss_cls`. With the flag clear, the instruction raises no driver enable.
- R5: A slot with valid low has no effect on any enable, whatever its other fields hold.
- R6: In the cycle after an edge at which reset is sampled high, every enable is high. In the first cycle after reset is released, every enable is low when nothing has issued.
- R7: Each gated clock equals the clock ANDed with its enable as held at the end of the preceding low phase. The gated clock stays low for a whole high phase when that enable was low.
- R8: An enable stays high only for the cycles in which its resource is used. A single issue raises a unit, latch or port enable for one cycle, and the enable is low again in the next cycle unless a new issue uses the resource.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | SLOTS | Per-slot valid of the issued group |
| iss_unit | input | SLOTS*UNIT_W | Per-slot target unit index |
| iss_cls | input | SLOTS*CLS_W | Per-slot unit class |
| iss_mem | input | SLOTS | Per-slot memory-access flag |
| iss_wr | input | SLOTS | Per-slot writes-result flag |
| unit_en | output | NUM_UNITS | Execution-unit enables |
| latch_en | output | SLOTS | Back-end latch-slot enables |
| dport_en | output | NUM_PORTS | Decoder-port enables |
| drv_en | output | NUM_UNITS | Result-bus driver enables |
| unit_gclk | output | NUM_UNITS | Gated clocks for the units |
| latch_gclk | output | SLOTS | Gated clocks for the latch slots |
| dport_gclk | output | NUM_PORTS | Gated clocks for the decoder ports |
| drv_gclk | output | NUM_UNITS | Gated clocks for the result-bus drivers |

## Verification
The assertions take for granted that no issued group carries more memory accesses than there are decoder ports. They also assume that each driver's writeback slot is claimed by at most what the OR of classes can represent. The port-count and thermometer properties only have meaning under the first assumption. Every stimulus pattern in the bench clears the memory flag of later slots once four memory accesses are present in a group. The driver-idle property allows a window of MAX_DLY cycles after the last writing issue. The bench leaves idle gaps between sweep entries, which exercises that window.

// File: rtl/icg_pkg.sv
package icg_pkg;
  localparam int DLY_W = 4;

  function automatic int unsigned pop64(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/icg_cell.sv
module icg_cell (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_l;

  // open while the clock is low, so the AND sees a stable enable during the high phase
  always_latch begin
    if (!clk) en_l <= en;
  end

  assign gclk = clk & en_l;
endmodule

// File: rtl/icg_unit_dec.sv
module icg_unit_dec #(
  parameter int SLOTS     = 8,
  parameter int NUM_UNITS = 8,
  parameter int UNIT_W    = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frc,
  input  logic [SLOTS-1:0]        iss_valid,
  input  logic [SLOTS*UNIT_W-1:0] iss_unit,
  output logic [NUM_UNITS-1:0]    unit_en,
  output logic [SLOTS-1:0]        latch_en
);
  logic [NUM_UNITS-1:0] hit;
  logic [NUM_UNITS-1:0] unit_q;
  logic [SLOTS-1:0]     latch_q;

  always_comb begin
    hit = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (iss_valid[s]) hit[iss_unit[s*UNIT_W +: UNIT_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_q  <= '0;
      latch_q <= '0;
    end else begin
      unit_q  <= hit;
      latch_q <= iss_valid;
    end
  end

  assign unit_en  = unit_q | {NUM_UNITS{frc}};
  assign latch_en = latch_q | {SLOTS{frc}};

  // R1: a unit enable needs some valid slot in the issue cycle
  p_unit_src_r1: assert property (@(posedge clk) disable iff (rst || frc)
    (|unit_en) |-> $past(|iss_valid));

  // R2: latch enables count the valid slots of the previous cycle
  p_latch_cnt_r2: assert property (@(posedge clk) disable iff (rst || frc)
    $countones(latch_en) == $past($countones(iss_valid)));
endmodule

// File: rtl/icg_port_alloc.sv
module icg_port_alloc #(
  parameter int SLOTS     = 8,
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frc,
  input  logic [SLOTS-1:0]     iss_valid,
  input  logic [SLOTS-1:0]     iss_mem,
  output logic [NUM_PORTS-1:0] dport_en
);
  import icg_pkg::*;

  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [CNT_W-1:0]     n_mem;
  logic [NUM_PORTS-1:0] therm;
  logic [NUM_PORTS-1:0] port_q;

  always_comb begin
    n_mem = '0;
    for (int s = 0; s < SLOTS; s++) n_mem = n_mem + CNT_W'(iss_valid[s] & iss_mem[s]);
    for (int p = 0; p < NUM_PORTS; p++) therm[p] = int'(n_mem) > p;
  end

  always_ff @(posedge clk) begin
    if (rst) port_q <= '0;
    else     port_q <= therm;
  end

  assign dport_en = port_q | {NUM_PORTS{frc}};

  // R3: input budget, never more accesses than ports
  p_port_budget_r3: assert property (@(posedge clk) disable iff (rst)
    pop64(64'(iss_valid & iss_mem)) <= NUM_PORTS);

  // R3: enabled ports are contiguous from port 0
  p_port_therm_r3: assert property (@(posedge clk) disable iff (rst)
    (dport_en & (dport_en + 1'b1)) == '0);

  // R3: as many ports as memory accesses one cycle earlier
  p_port_count_r3: assert property (@(posedge clk) disable iff (rst || frc)
    $countones(dport_en) == $past($countones(iss_valid & iss_mem)));
endmodule

// File: rtl/icg_wb_track.sv
module icg_wb_track #(
  parameter int SLOTS     = 8,
  parameter int NUM_UNITS = 8,
  parameter int UNIT_W    = 3,
  parameter int NUM_CLS   = 4,
  parameter int CLS_W     = 2,
  parameter int MAX_DLY   = 4,
  parameter logic [NUM_CLS*icg_pkg::DLY_W-1:0] CLS_DLY = 16'h4321
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frc,
  input  logic [SLOTS-1:0]        iss_valid,
  input  logic [SLOTS*UNIT_W-1:0] iss_unit,
  input  logic [SLOTS*CLS_W-1:0]  iss_cls,
  input  logic [SLOTS-1:0]        iss_wr,
  output logic [NUM_UNITS-1:0]    drv_en
);
  import icg_pkg::*;

  localparam int IW = $clog2(MAX_DLY + 1);

  logic [NUM_UNITS-1:0] tap [NUM_CLS];
  logic [NUM_UNITS-1:0] drv_or;
  logic [IW-1:0]        idle;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    localparam int D = int'(CLS_DLY[c*DLY_W +: DLY_W]);
    logic [NUM_UNITS-1:0] fill;
    logic [NUM_UNITS-1:0] stg [D];

    always_comb begin
      fill = '0;
      for (int s = 0; s < SLOTS; s++) begin
        if (iss_valid[s] && iss_wr[s] && iss_cls[s*CLS_W +: CLS_W] == CLS_W'(c))
          fill[iss_unit[s*UNIT_W +: UNIT_W]] = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < D; k++) stg[k] <= '0;
      end else begin
        stg[0] <= fill;
        for (int k = 1; k < D; k++) stg[k] <= stg[k-1];
      end
    end

    assign tap[c] = stg[D-1];
  end

  always_comb begin
    drv_or = '0;
    for (int c = 0; c < NUM_CLS; c++) drv_or = drv_or | tap[c];
  end

  assign drv_en = drv_or | {NUM_UNITS{frc}};

  // cycles since the last writing issue, saturating (checker window)
  always_ff @(posedge clk) begin
    if (rst)                      idle <= IW'(MAX_DLY);
    else if (|(iss_valid & iss_wr)) idle <= '0;
    else if (idle < IW'(MAX_DLY)) idle <= idle + 1'b1;
  end

  // R4: once the longest delay has passed with no writer, all drivers are off
  p_drv_idle_r4: assert property (@(posedge clk) disable iff (rst || frc)
    (idle == IW'(MAX_DLY)) |-> (drv_en == '0));
endmodule

// File: rtl/issue_clk_gate_ctrl.sv
module issue_clk_gate_ctrl #(
  parameter int SLOTS     = 8,
  parameter int NUM_UNITS = 8,
  parameter int UNIT_W    = $clog2(NUM_UNITS),
  parameter int NUM_CLS   = 4,
  parameter int CLS_W     = $clog2(NUM_CLS),
  parameter int NUM_PORTS = 4,
  parameter int MAX_DLY   = 4,
  parameter logic [NUM_CLS*icg_pkg::DLY_W-1:0] CLS_DLY = 16'h4321
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SLOTS-1:0]        iss_valid,
  input  logic [SLOTS*UNIT_W-1:0] iss_unit,
  input  logic [SLOTS*CLS_W-1:0]  iss_cls,
  input  logic [SLOTS-1:0]        iss_mem,
  input  logic [SLOTS-1:0]        iss_wr,
  output logic [NUM_UNITS-1:0]    unit_en,
  output logic [SLOTS-1:0]        latch_en,
  output logic [NUM_PORTS-1:0]    dport_en,
  output logic [NUM_UNITS-1:0]    drv_en,
  output logic [NUM_UNITS-1:0]    unit_gclk,
  output logic [SLOTS-1:0]        latch_gclk,
  output logic [NUM_PORTS-1:0]    dport_gclk,
  output logic [NUM_UNITS-1:0]    drv_gclk
);
  logic frc;

  // one-cycle all-on pulse that follows each sampled reset
  always_ff @(posedge clk) frc <= rst;

  icg_unit_dec #(.SLOTS(SLOTS), .NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)) u_dec (
    .clk(clk), .rst(rst), .frc(frc), .iss_valid(iss_valid), .iss_unit(iss_unit),
    .unit_en(unit_en), .latch_en(latch_en));

  icg_port_alloc #(.SLOTS(SLOTS), .NUM_PORTS(NUM_PORTS)) u_port (
    .clk(clk), .rst(rst), .frc(frc), .iss_valid(iss_valid), .iss_mem(iss_mem),
    .dport_en(dport_en));

  icg_wb_track #(.SLOTS(SLOTS), .NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W), .NUM_CLS(NUM_CLS),
    .CLS_W(CLS_W), .MAX_DLY(MAX_DLY), .CLS_DLY(CLS_DLY)) u_wb (
    .clk(clk), .rst(rst), .frc(frc), .iss_valid(iss_valid), .iss_unit(iss_unit),
    .iss_cls(iss_cls), .iss_wr(iss_wr), .drv_en(drv_en));

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_ucell
    icg_cell u_cu (.clk(clk), .en(unit_en[i]), .gclk(unit_gclk[i]));
    icg_cell u_cd (.clk(clk), .en(drv_en[i]),  .gclk(drv_gclk[i]));
  end
  for (genvar i = 0; i < SLOTS; i++) begin : g_lcell
    icg_cell u_cl (.clk(clk), .en(latch_en[i]), .gclk(latch_gclk[i]));
  end
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_pcell
    icg_cell u_cp (.clk(clk), .en(dport_en[i]), .gclk(dport_gclk[i]));
  end

  // R6: a sampled reset turns every enable on for the next cycle
  p_reset_all_r6: assert property (@(posedge clk)
    rst |=> (&unit_en && &latch_en && &dport_en && &drv_en));

  // R8: without any valid slot, no unit or latch is enabled next cycle
  p_quiet_next_r8: assert property (@(posedge clk) disable iff (rst || frc)
    $past(iss_valid == '0) |-> (unit_en == '0 && latch_en == '0 && dport_en == '0));
endmodule

// File: tb/issue_clk_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module issue_clk_gate_ctrl_tb_top;
  localparam int S = 8, U = 8, UW = 3, C = 4, CW = 2, P = 4, H = 4;
  localparam int DLY [C] = '{1, 2, 3, 4};

  logic clk = 1'b0, rst = 1'b1;
  logic [S-1:0] iss_valid = '0, iss_mem = '0, iss_wr = '0;
  logic [S*UW-1:0] iss_unit = '0;
  logic [S*CW-1:0] iss_cls = '0;
  logic [U-1:0] unit_en, drv_en, unit_gclk, drv_gclk;
  logic [S-1:0] latch_en, latch_gclk;
  logic [P-1:0] dport_en, dport_gclk;

  int checks = 0, failures = 0;
  logic [S-1:0]    hv [H+1], hm [H+1], hw [H+1];
  logic [S*UW-1:0] hu [H+1];
  logic [S*CW-1:0] hc [H+1];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  issue_clk_gate_ctrl dut_i (.clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_unit(iss_unit),
    .iss_cls(iss_cls), .iss_mem(iss_mem), .iss_wr(iss_wr), .unit_en(unit_en), .latch_en(latch_en),
    .dport_en(dport_en), .drv_en(drv_en), .unit_gclk(unit_gclk), .latch_gclk(latch_gclk),
    .dport_gclk(dport_gclk), .drv_gclk(drv_gclk));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: check outputs for past issues, then drive the next group
  task automatic step(input logic [S-1:0] v, input logic [S*UW-1:0] u,
                      input logic [S*CW-1:0] c, input logic [S-1:0] m, input logic [S-1:0] w);
    logic [U-1:0] eu, ed, su, sd;
    logic [S-1:0] sl;
    logic [P-1:0] ep, sp;
    int k;
    @(negedge clk);
    for (int i = H; i > 1; i--) begin
      hv[i] = hv[i-1]; hm[i] = hm[i-1]; hw[i] = hw[i-1]; hu[i] = hu[i-1]; hc[i] = hc[i-1];
    end
    hv[1] = iss_valid; hm[1] = iss_mem; hw[1] = iss_wr; hu[1] = iss_unit; hc[1] = iss_cls;
    eu = '0; k = 0;
    for (int s = 0; s < S; s++) if (hv[1][s]) begin
      eu[hu[1][s*UW +: UW]] = 1'b1;
      if (hm[1][s]) k++;
    end
    ep = '0;
    for (int p = 0; p < P; p++) ep[p] = (p < k);
    ed = '0;
    for (int cl = 0; cl < C; cl++)
      for (int s = 0; s < S; s++)
        if (hv[DLY[cl]][s] && hw[DLY[cl]][s] && hc[DLY[cl]][s*CW +: CW] == CW'(cl))
          ed[hu[DLY[cl]][s*UW +: UW]] = 1'b1;
    chk("R1/R5/R8 unit_en", 32'(unit_en), 32'(eu));
    chk("R2/R5 latch_en", 32'(latch_en), 32'(hv[1]));
    chk("R3 dport_en", 32'(dport_en), 32'(ep));
    chk("R4 drv_en", 32'(drv_en), 32'(ed));
    su = unit_en; sd = drv_en; sl = latch_en; sp = dport_en;
    iss_valid = v; iss_unit = u; iss_cls = c; iss_mem = m; iss_wr = w;
    @(posedge clk); #1;
    chk("R7 unit_gclk", 32'(unit_gclk), 32'(su));
    chk("R7 drv_gclk", 32'(drv_gclk), 32'(sd));
    chk("R7 latch_gclk", 32'(latch_gclk), 32'(sl));
    chk("R7 dport_gclk", 32'(dport_gclk), 32'(sp));
  endtask

  function automatic logic [S-1:0] cap_mem(input logic [S-1:0] v, input logic [S-1:0] m);
    int n = 0;
    cap_mem = '0;
    for (int s = 0; s < S; s++) if (m[s] && (!v[s] || n < P)) begin
      cap_mem[s] = 1'b1;
      if (v[s]) n++;
    end
  endfunction

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i <= H; i++) begin
      hv[i] = '0; hm[i] = '0; hw[i] = '0; hu[i] = '0; hc[i] = '0;
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 all-on unit", 32'(unit_en), 32'(8'hFF));
    chk("R6 all-on latch", 32'(latch_en), 32'(8'hFF));
    chk("R6 all-on port", 32'(dport_en), 32'(4'hF));
    chk("R6 all-on drv", 32'(drv_en), 32'(8'hFF));
    rst = 1'b0;
    @(negedge clk);
    chk("R6 off unit", 32'(unit_en), 0);
    chk("R6 off latch", 32'(latch_en), 0);
    chk("R6 off port", 32'(dport_en), 0);
    chk("R6 off drv", 32'(drv_en), 0);

    // single instruction per group: every slot, unit, class and write flag (R1 R2 R4 R8)
    for (int s = 0; s < S; s++)
      for (int u = 0; u < U; u++)
        for (int c = 0; c < C; c++)
          for (int w = 0; w < 2; w++) begin
            step(S'(1) << s, (S*UW)'(u) << (s*UW), (S*CW)'(c) << (s*CW),
                 S'(u & 1) << s, S'(w) << s);
            if (((u + c) % 3) == 0) step('0, '0, '0, '0, '0);
          end
    repeat (H + 1) step('0, '0, '0, '0, '0);

    // memory counts 0..P from low and high slots (R3)
    for (int k = 0; k <= P; k++) begin
      step('1, '0, '0, S'((1 << k) - 1), '0);
      step('1, '0, '0, S'(((1 << k) - 1) << (S - k)), '0);
      step(8'b1010_1010, '0, '0, cap_mem(8'b1010_1010, 8'hFF), '0);
    end

    // invalid slots carrying every other field (R5)
    for (int i = 0; i < 6; i++) step('0, {S*UW{1'b1}}, {S*CW{1'b1}}, '1, '1);
    repeat (H + 1) step('0, '1, '1, '1, '1);

    // mixed traffic from a linear feedback register
    for (int n = 0; n < 1500; n++) begin
      logic [S-1:0] v, m, w;
      logic [S*UW-1:0] u;
      logic [S*CW-1:0] c;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      v = lfsr[7:0] & lfsr[15:8];
      u = {lfsr[23:0]} ^ {lfsr[7:0], lfsr[31:16]};
      c = lfsr[31:16];
      w = lfsr[27:20];
      m = cap_mem(v, lfsr[19:12]);
      step(v, u, c, m, w);
    end
    repeat (H + 1) step('0, '0, '0, '0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule